// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block sits behind an external dual-modulus prescaler that divides by P or P+1. It counts the prescaler's output pulses and drives the modulus-select line. At the start of every division cycle the select line is low, so the prescaler divides by P+1. The select line stays low until a programmed number of pulses, the swallow count A, has passed. It then goes high, so the prescaler divides by P, for the rest of the programmed main count M. When the main count completes, the block emits a one-clock strobe and starts the next cycle. Each cycle therefore spans A·(P+1) + (M−A)·P = M·P + A prescaler input periods.

The prescaler pulses arrive as `fin`, a synchronous qualifier: every clock in which it is high counts as one pulse. A `load` strobe captures new A and M values and restarts the cycle from zero. The block is otherwise idle from reset until the first load. A configuration flag reports programmed values that cannot give a correct division.

The controller is a three-state machine:
- `ST_HOLD`: idle after reset.
- `ST_SWALLOW`: select line low.
- `ST_FILL`: select line high.

Its transitions are:
- **arm**: from any state on `load`, to SWALLOW, or to FILL when the new A is zero.
- **swallow_done**: SWALLOW to FILL on the A-th pulse.
- **wrap**: from SWALLOW or FILL on the M-th pulse, back to SWALLOW, or to FILL when A is zero.

Top module: `swl_ctrl`

## Requirements
- R1: After reset `mc`, `fv_pulse` and `cfg_err` are 0, and `fin` pulses are ignored (no `mc` change, no strobe) until the first `load`.
- R2: A `load` captures `a_val`/`m_val` and restarts the cycle with zero pulses counted. In the next clock `fv_pulse` is 0 and `mc` equals 1 exactly when the captured A is 0. `load` takes priority over `fin` in the same clock.
- R3: Each clock with `fin` high counts one pulse. After the pulse that brings the cycle's count to A, `mc` changes from 0 to 1 in the following clock.
- R4: On the M-th pulse of a cycle, `fv_pulse` is 1 for exactly the next clock. A new cycle then begins with `mc` at 0, so every M pulses yield one strobe.
- R5: With A = 0, `mc` is 1 for the whole cycle, including directly after the wrap.
- R6: With M ≤ A, `mc` stays 0 throughout, and the cycle still wraps after M pulses.
- R7: `cfg_err` is 1 exactly when the last loaded values have M < A or M < 8. It is updated in the clock after `load`.
- R8: Changes on `a_val`/`m_val` without `load` have no effect on `mc`, `fv_pulse` or `cfg_err`.
- R9: In a clock with neither `fin` nor `load`, `mc` keeps its value and `fv_pulse` is 0 in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fin | input | 1 | Prescaler output pulse qualifier, one pulse per high clock |
| a_val | input | 7 | Swallow count A (0..127) |
| m_val | input | 10 | Main count M (8..1023 for correct operation) |
| load | input | 1 | Capture A/M and restart the division cycle |
| mc | output | 1 | Modulus select: 0 selects P+1, 1 selects P |
| fv_pulse | output | 1 | One-clock strobe per completed division cycle |
| cfg_err | output | 1 | Loaded values violate M ≥ A or M ≥ 8 |

## Verification
The hardest cases to reach are those where two counter events fall on the same pulse. One is M equal to A, where the swallow completion and the wrap coincide and the wrap must win. The other is a `load` that lands in the same clock as a `fin` pulse in the middle of a cycle. The stimulus programs M = A and M < A directly. It asserts `load` together with `fin` at an arbitrary point inside a running cycle. It also uses a gapped `fin` pattern, so that completion pulses arrive both back-to-back and after idle clocks. A behavioural pulse-position model in the bench predicts every clock.

// File: rtl/swl_pkg.sv
package swl_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_FILL    = 2'd2
    } swl_state_e;
endpackage

// File: rtl/swl_cnt.sv
module swl_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + ONE;
        end
    end
endmodule

// File: rtl/swl_cfg.sv
module swl_cfg #(
    parameter int A_W   = 7,
    parameter int M_W   = 10,
    parameter int M_MIN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W-1:0] a_val,
    input  logic [M_W-1:0] m_val,
    output logic [A_W-1:0] a_cur,
    output logic [M_W-1:0] m_cur,
    output logic           cfg_err
);
    localparam logic [M_W-1:0] M_FLOOR = M_W'(M_MIN);

    logic bad_order;
    logic bad_floor;

    always_comb begin
        bad_order = m_val < M_W'(a_val);
        bad_floor = m_val < M_FLOOR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_cur   <= '0;
            m_cur   <= M_FLOOR;
            cfg_err <= 1'b0;
        end else if (load) begin
            a_cur   <= a_val;
            m_cur   <= m_val;
            cfg_err <= bad_order | bad_floor;
        end
    end
endmodule

// File: rtl/swl_ctrl.sv
module swl_ctrl #(
    parameter int A_W   = 7,
    parameter int M_W   = 10,
    parameter int M_MIN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fin,
    input  logic [A_W-1:0] a_val,
    input  logic [M_W-1:0] m_val,
    input  logic           load,
    output logic           mc,
    output logic           fv_pulse,
    output logic           cfg_err
);
    import swl_pkg::*;

    localparam logic [A_W-1:0] A_ONE = {{(A_W-1){1'b0}}, 1'b1};
    localparam logic [M_W-1:0] M_ONE = {{(M_W-1){1'b0}}, 1'b1};

    swl_state_e     state_q;
    swl_state_e     state_d;
    logic [A_W-1:0] a_cur;
    logic [M_W-1:0] m_cur;
    logic [A_W-1:0] a_cnt;
    logic [M_W-1:0] m_cnt;
    logic           running;
    logic           wrap_hit;
    logic           swallow_hit;
    logic           a_clr;
    logic           a_inc;
    logic           m_clr;
    logic           m_inc;
    logic           fv_q;

    swl_cfg #(.A_W(A_W), .M_W(M_W), .M_MIN(M_MIN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .a_val   (a_val),
        .m_val   (m_val),
        .a_cur   (a_cur),
        .m_cur   (m_cur),
        .cfg_err (cfg_err)
    );

    // Event decode: the wrap has priority over the swallow completion.
    always_comb begin
        running     = (state_q != ST_HOLD);
        wrap_hit    = fin && running && ((m_cnt + M_ONE) == m_cur);
        swallow_hit = fin && (state_q == ST_SWALLOW) && !wrap_hit
                      && ((a_cnt + A_ONE) == a_cur);
        a_clr       = load || wrap_hit;
        m_clr       = load || wrap_hit;
        a_inc       = fin && (state_q == ST_SWALLOW);
        m_inc       = fin && running;
    end

    swl_cnt #(.W(A_W)) u_a_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (a_clr),
        .inc   (a_inc),
        .q     (a_cnt)
    );

    swl_cnt #(.W(M_W)) u_m_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (m_clr),
        .inc   (m_inc),
        .q     (m_cnt)
    );

    // Transitions: arm (load), wrap (M-th pulse), swallow_done (A-th pulse).
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = (a_val == '0) ? ST_FILL : ST_SWALLOW;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    state_d = ST_HOLD;
                end
                ST_SWALLOW: begin
                    if (wrap_hit) begin
                        state_d = (a_cur == '0) ? ST_FILL : ST_SWALLOW;
                    end else if (swallow_hit) begin
                        state_d = ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (wrap_hit) begin
                        state_d = (a_cur == '0) ? ST_FILL : ST_SWALLOW;
                    end
                end
                default: begin
                    state_d = ST_HOLD;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            fv_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            fv_q    <= wrap_hit && !load;
        end
    end

    // Output process.
    always_comb begin
        mc       = (state_q == ST_FILL);
        fv_pulse = fv_q;
    end
endmodule

// File: rtl/swl_ctrl_chk.sv
module swl_ctrl_chk #(
    parameter int A_W = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fin,
    input logic           load,
    input logic [A_W-1:0] a_val,
    input logic           mc,
    input logic           fv_pulse,
    input logic           cfg_err
);
    AST_STROBE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n) fv_pulse |-> $past(fin) && !$past(load)); // R4
    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n) load |=> (!fv_pulse && (mc == ($past(a_val) == '0)))); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!fin && !load) |=> ($stable(mc) && !fv_pulse)); // R9
    AST_MC_FALL_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) $fell(mc) |-> (fv_pulse || $past(load))); // R4
    AST_ERR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(cfg_err)); // R8
endmodule

bind swl_ctrl swl_ctrl_chk #(.A_W(A_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fin      (fin),
    .load     (load),
    .a_val    (a_val),
    .mc       (mc),
    .fv_pulse (fv_pulse),
    .cfg_err  (cfg_err)
);

// File: tb/swl_ctrl_bench.sv
module swl_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fin = 1'b0;
    logic [6:0] a_val = '0;
    logic [9:0] m_val = 10'd8;
    logic       load = 1'b0;
    logic       mc;
    logic       fv_pulse;
    logic       cfg_err;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;
    string req = "R1";

    // behavioural model state
    int pos = 0;
    int ma = 0;
    int mm = 8;
    bit run = 0;
    bit fv_e = 0;
    bit err_e = 0;

    always #2 clk = ~clk;

    swl_ctrl u_swl_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin      (fin),
        .a_val    (a_val),
        .m_val    (m_val),
        .load     (load),
        .mc       (mc),
        .fv_pulse (fv_pulse),
        .cfg_err  (cfg_err)
    );

    task automatic chk(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", r, what, act, exp, $time);
        end
    endtask

    function automatic bit mc_model();
        return run && (pos >= ma);
    endfunction

    task automatic step(input bit f, input bit l);
        fin  = f;
        load = l;
        @(posedge clk);
        if (l) begin
            ma = int'(a_val); mm = int'(m_val); pos = 0; run = 1; fv_e = 0;
            err_e = (mm < ma) || (mm < 8);
        end else if (run && f) begin
            pos++;
            if (pos == mm) begin pos = 0; fv_e = 1; end
            else fv_e = 0;
        end else begin
            fv_e = 0;
        end
        @(negedge clk);
        fin = 1'b0; load = 1'b0;
        chk(req, "mc", int'(mc), int'(mc_model()));
        chk(req, "fv_pulse", int'(fv_pulse), int'(fv_e));
        chk(req, "cfg_err", int'(cfg_err), int'(err_e));
    endtask

    task automatic do_load(input int a, input int m, input bit f);
        a_val = 7'(a);
        m_val = 10'(m);
        step(f, 1'b1);
    endtask

    int fv_count;

    initial begin
        repeat (3) @(negedge clk);
        req = "R1";
        chk("R1", "mc at reset", int'(mc), 0);
        chk("R1", "fv at reset", int'(fv_pulse), 0);
        chk("R1", "err at reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0);   // R1: pulses ignored while idle

        // R3/R4: continuous pulses, A=3, M=10
        req = "R3";
        do_load(3, 10, 1'b0);
        fv_count = 0;
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 1'b0);
            if (fv_pulse) fv_count++;
        end
        chk("R4", "strobes per 30 pulses at M=10", fv_count, 3);

        // R8/R9: inputs change without load, gapped pulses
        req = "R8";
        a_val = 7'd50; m_val = 10'd9;
        for (int i = 0; i < 45; i++) step((i % 3) != 0, 1'b0);
        req = "R9";
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0);

        // R5: A=0
        req = "R5";
        do_load(0, 8, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
        chk("R5", "mc high after wraps", int'(mc), 1);

        // R6: M==A and M<A
        req = "R6";
        do_load(9, 9, 1'b0);
        for (int i = 0; i < 22; i++) step((i % 4) != 1, 1'b0);
        req = "R7";
        do_load(20, 10, 1'b0);
        chk("R7", "err for M<A", int'(cfg_err), 1);
        req = "R6";
        for (int i = 0; i < 25; i++) step(1'b1, 1'b0);

        // R7: M below floor
        req = "R7";
        do_load(2, 5, 1'b0);
        chk("R7", "err for M<8", int'(cfg_err), 1);
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0);
        do_load(8, 8, 1'b0);
        chk("R7", "err cleared for M=A=8", int'(cfg_err), 0);

        // R2: load with fin in the same clock, mid-cycle
        req = "R2";
        do_load(4, 12, 1'b0);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
        do_load(1, 9, 1'b1);
        chk("R2", "mc after mid-cycle load A=1", int'(mc), 0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
        do_load(0, 11, 1'b1);
        chk("R2", "mc after load A=0", int'(mc), 1);
        for (int i = 0; i < 15; i++) step((i % 2) == 0, 1'b0);

        // R3/R4: large values
        req = "R3";
        do_load(127, 130, 1'b0);
        for (int i = 0; i < 300; i++) step((i % 5) != 4, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end
endmodule